// File: doc/BRIEF.md
# Multi-Bin Carrier Replica Generator

This block produces a comb of carrier replicas, evenly spaced in frequency around a tracked centre carrier, so that a correlator can test several Doppler hypotheses against the same input samples. Two phase accumulators advance once per input sample. The centre accumulator carries the tracked carrier phase. The spacing accumulator carries the phase that separates neighbouring bins. Each bin's phase is formed from these two values using adders only.

On every sample enable the block sweeps the configured bins in order, one per clock. For each bin it emits the bin index, the full phase word, and a pair of small signed cosine/sine values taken from an eight-entry table. The same design covers a wide acquisition comb with many coarse bins, a narrow assisted comb with a few fine bins, and a single bin for tracking. The bin spacing in frequency is twice the spacing word. The spacing word is then chosen so that the bin width stays under one over twice the coherent integration time.

Top module: `multibin_carrier_gen`

## Requirements
- R1: After reset, rep_valid_o is low and both accumulators hold zero, so the first enable yields a centre phase equal to the centre word.
- R2: Each sample enable adds centre_fcw_i to the centre accumulator C and spacing_fcw_i to the spacing accumulator H, both modulo 2^32.
- R3: The edge that samples sample_en_i high is edge E0. Bin 0 is emitted at edge E1 and bins 1 to N-1 follow on consecutive edges, with rep_valid_o low at every other time.
- R4: Bin k carries phase C + (2k-(N-1))*H modulo 2^32, where C and H are the values after that enable's update.
- R5: Bins k and N-1-k have phases that sum to 2C modulo 2^32, and for odd N the middle bin equals C.
- R6: The bin count N is taken from num_bins_i at the enable: 0 gives one bin, and values above 32 give 32.
- R7: The table index is rep_phase_o[31:29]. For indices 0 to 7, rep_i_o is 3,2,0,-2,-3,-2,0,2 and rep_q_o equals rep_i_o's table value at index (idx-2) mod 8 (a sine).
- R8: A new centre or spacing word takes effect at the enable that presents it and does not reset phase, so the per-sample advance of bin k equals centre word + (2k-(N-1))*spacing word.
- R9: With one bin, the single emitted phase equals the centre phase C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_en_i | input | 1 | One-cycle pulse per input sample |
| centre_fcw_i | input | 32 | Centre carrier frequency word |
| spacing_fcw_i | input | 32 | Half bin-spacing frequency word |
| num_bins_i | input | 6 | Requested bin count |
| rep_valid_o | output | 1 | Replica output valid |
| rep_bin_o | output | 5 | Bin index of current replica |
| rep_phase_o | output | 32 | Phase word of current replica |
| rep_i_o | output | 3 | Signed in-phase replica |
| rep_q_o | output | 3 | Signed quadrature replica |

## Verification
The bench builds the block with its default 32-bit phase and a 32-bin ceiling. That ceiling puts a 17-bin acquisition comb, a 4-bin fine comb, a single tracking bin, and both clamping limits (0 and above 32) within reach. Large words drive the accumulators through modulo wrap, so the signed offsets of the outer bins and the symmetry about the centre are exercised across the wrap point. Repeated enables with unchanged and with changed words expose the per-sample advance of every bin.

// File: rtl/mbcr_pkg.sv
package mbcr_pkg;
  localparam int LUT_BITS = 3;
  localparam int AMP_W    = 3;

  typedef logic signed [AMP_W-1:0] amp_t;
  typedef logic [LUT_BITS-1:0]     lut_idx_t;

  // eight-point cosine, amplitude 3
  function automatic amp_t cos_lut(lut_idx_t idx);
    case (idx)
      3'd0:    return amp_t'(3);
      3'd1:    return amp_t'(2);
      3'd2:    return amp_t'(0);
      3'd3:    return amp_t'(-2);
      3'd4:    return amp_t'(-3);
      3'd5:    return amp_t'(-2);
      3'd6:    return amp_t'(0);
      default: return amp_t'(2);
    endcase
  endfunction

  function automatic amp_t sin_lut(lut_idx_t idx);
    return cos_lut(idx - lut_idx_t'(2));
  endfunction
endpackage

// File: rtl/mbcr_phase_acc.sv
module mbcr_phase_acc #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] step_i,
  output logic [W-1:0] acc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_o <= '0;
    else if (en_i) acc_o <= acc_o + step_i;
  end
endmodule

// File: rtl/mbcr_offset_mult.sv
// Shift-add product m_i * a_i modulo 2^W
module mbcr_offset_mult #(
  parameter int W  = 32,
  parameter int MW = 5
) (
  input  logic [MW-1:0] m_i,
  input  logic [W-1:0]  a_i,
  output logic [W-1:0]  p_o
);
  logic [W-1:0] part [MW];
  logic [W-1:0] sum  [MW+1];

  assign sum[0] = '0;
  for (genvar gi = 0; gi < MW; gi++) begin : g_pp
    assign part[gi]  = m_i[gi] ? W'(a_i << gi) : '0;
    assign sum[gi+1] = sum[gi] + part[gi];
  end
  assign p_o = sum[MW];
endmodule

// File: rtl/mbcr_sweep.sv
module mbcr_sweep #(
  parameter int W     = 32,
  parameter int BIN_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [BIN_W-1:0] last_i,
  input  logic [W-1:0]     base_i,
  input  logic [W-1:0]     step_i,
  output logic             valid_o,
  output logic [BIN_W-1:0] bin_o,
  output logic [W-1:0]     phase_o
);
  logic             busy_q;
  logic [BIN_W-1:0] k_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      k_q     <= '0;
      valid_o <= 1'b0;
      bin_o   <= '0;
      phase_o <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      k_q     <= '0;
      valid_o <= 1'b0;
    end else if (busy_q) begin
      valid_o <= 1'b1;
      bin_o   <= k_q;
      phase_o <= (k_q == '0) ? base_i : phase_o + step_i;
      if (k_q == last_i) busy_q <= 1'b0;
      else               k_q    <= k_q + 1'b1;
    end else begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mbcr_sincos.sv
module mbcr_sincos
  import mbcr_pkg::*;
(
  input  lut_idx_t idx_i,
  output amp_t     i_o,
  output amp_t     q_o
);
  assign i_o = cos_lut(idx_i);
  assign q_o = sin_lut(idx_i);
endmodule

// File: rtl/multibin_carrier_gen.sv
module multibin_carrier_gen
  import mbcr_pkg::*;
#(
  parameter int PHASE_W  = 32,
  parameter int MAX_BINS = 32,
  localparam int BIN_W   = $clog2(MAX_BINS),
  localparam int CNT_W   = $clog2(MAX_BINS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sample_en_i,
  input  logic [PHASE_W-1:0] centre_fcw_i,
  input  logic [PHASE_W-1:0] spacing_fcw_i,
  input  logic [CNT_W-1:0]   num_bins_i,
  output logic               rep_valid_o,
  output logic [BIN_W-1:0]   rep_bin_o,
  output logic [PHASE_W-1:0] rep_phase_o,
  output logic [AMP_W-1:0]   rep_i_o,
  output logic [AMP_W-1:0]   rep_q_o
);
  logic [PHASE_W-1:0] centre_acc, spacing_acc, offset, base;
  logic [BIN_W-1:0]   last_d, last_q;
  amp_t               i_s, q_s;

  mbcr_phase_acc #(.W(PHASE_W)) u_centre (
    .clk_i, .rst_ni, .en_i(sample_en_i), .step_i(centre_fcw_i), .acc_o(centre_acc)
  );
  mbcr_phase_acc #(.W(PHASE_W)) u_spacing (
    .clk_i, .rst_ni, .en_i(sample_en_i), .step_i(spacing_fcw_i), .acc_o(spacing_acc)
  );

  always_comb begin
    if (num_bins_i == '0)                        last_d = '0;
    else if (num_bins_i > CNT_W'(MAX_BINS))      last_d = BIN_W'(MAX_BINS - 1);
    else                                         last_d = BIN_W'(num_bins_i - 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          last_q <= '0;
    else if (sample_en_i) last_q <= last_d;
  end

  // lowest bin sits (N-1) half-steps below centre
  mbcr_offset_mult #(.W(PHASE_W), .MW(BIN_W)) u_offset (
    .m_i(last_q), .a_i(spacing_acc), .p_o(offset)
  );
  assign base = centre_acc - offset;

  mbcr_sweep #(.W(PHASE_W), .BIN_W(BIN_W)) u_sweep (
    .clk_i, .rst_ni,
    .start_i(sample_en_i),
    .last_i(last_q),
    .base_i(base),
    .step_i({spacing_acc[PHASE_W-2:0], 1'b0}),
    .valid_o(rep_valid_o),
    .bin_o(rep_bin_o),
    .phase_o(rep_phase_o)
  );

  mbcr_sincos u_lut (
    .idx_i(rep_phase_o[PHASE_W-1 -: LUT_BITS]), .i_o(i_s), .q_o(q_s)
  );
  assign rep_i_o = i_s;
  assign rep_q_o = q_s;
endmodule

// File: rtl/multibin_carrier_gen_chk.sv
module multibin_carrier_gen_chk #(
  parameter int PHASE_W = 32,
  parameter int BIN_W   = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sample_en_i,
  input logic               rep_valid_o,
  input logic [BIN_W-1:0]   rep_bin_o,
  input logic [PHASE_W-1:0] rep_phase_o,
  input logic [2:0]         rep_i_o,
  input logic [2:0]         rep_q_o
);
  // R3
  start_bin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_en_i |=> ##1 (rep_valid_o && rep_bin_o == '0));

  // R3
  consecutive_bin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rep_valid_o && rep_bin_o != '0) |-> ($past(rep_valid_o) && rep_bin_o == BIN_W'($past(rep_bin_o) + 1'b1)));

  // R3
  first_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rep_valid_o) |-> rep_bin_o == '0);

  // R4
  even_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rep_valid_o && rep_bin_o >= BIN_W'(2)) |->
      (rep_phase_o - $past(rep_phase_o) == $past(rep_phase_o) - $past(rep_phase_o, 2)));

  // R7
  amp_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rep_valid_o |-> (rep_i_o != 3'b100 && rep_q_o != 3'b100 && (rep_i_o != '0 || rep_q_o != '0)));
endmodule

bind multibin_carrier_gen multibin_carrier_gen_chk #(.PHASE_W(PHASE_W), .BIN_W(BIN_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sample_en_i(sample_en_i),
  .rep_valid_o(rep_valid_o), .rep_bin_o(rep_bin_o), .rep_phase_o(rep_phase_o),
  .rep_i_o(rep_i_o), .rep_q_o(rep_q_o)
);

// File: tb/multibin_carrier_gen_test.sv
module multibin_carrier_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_en = 1'b0;
  logic [31:0] fc = '0, fs = '0;
  logic [5:0]  nb = '0;
  logic        valid;
  logic [4:0]  bin;
  logic [31:0] phase;
  logic [2:0]  ri, rq;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct packed {
    logic [4:0]  bin;
    logic [31:0] ph;
    logic [2:0]  i;
    logic [2:0]  q;
  } item_t;
  item_t exp_q[$];

  logic [31:0] cm = '0, hm = '0;
  logic [31:0] obs[32];
  logic [31:0] prev[32];
  int obs_cnt = 0;
  int prev_n = -1;

  always #(CLK_PERIOD/2) clk = ~clk;

  multibin_carrier_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .sample_en_i(sample_en),
    .centre_fcw_i(fc), .spacing_fcw_i(fs), .num_bins_i(nb),
    .rep_valid_o(valid), .rep_bin_o(bin), .rep_phase_o(phase),
    .rep_i_o(ri), .rep_q_o(rq)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] cos_ref(input logic [2:0] idx);
    case (idx)
      3'd0: return 3'd3;      3'd1: return 3'd2;
      3'd2: return 3'd0;      3'd3: return 3'b110;
      3'd4: return 3'b101;    3'd5: return 3'b110;
      3'd6: return 3'd0;      default: return 3'd2;
    endcase
  endfunction

  function automatic logic [31:0] bin_phase(input int k, input int n);
    logic [31:0] m = 32'(2*k - (n-1));
    return cm + m * hm;
  endfunction

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (rst_n && valid) begin
      item_t e;
      if (exp_q.size() == 0) begin
        check(1'b0, "R3", "unexpected valid", {27'd0, bin}, 32'd0);
      end else begin
        e = exp_q.pop_front();
        check(bin == e.bin, "R3", "bin order", {27'd0, bin}, {27'd0, e.bin});
        check(phase == e.ph, "R4", "bin phase", phase, e.ph);
        check(ri == e.i && rq == e.q, "R7", "i/q table", {26'd0, ri, rq}, {26'd0, e.i, e.q});
        obs[bin] = phase;
        obs_cnt++;
      end
    end
  end

  task automatic run_sample(input logic [31:0] c, input logic [31:0] s, input int req_n);
    int n;
    n = (req_n == 0) ? 1 : (req_n > 32 ? 32 : req_n);
    cm = cm + c;
    hm = hm + s;
    for (int k = 0; k < n; k++) begin
      item_t it;
      it.bin = 5'(k);
      it.ph  = bin_phase(k, n);
      it.i   = cos_ref(it.ph[31:29]);
      it.q   = cos_ref(it.ph[31:29] - 3'd2);
      exp_q.push_back(it);
    end
    obs_cnt = 0;
    @(negedge clk);
    fc = c; fs = s; nb = 6'(req_n); sample_en = 1'b1;
    @(negedge clk);
    sample_en = 1'b0;
    check(!valid, "R3", "valid low one edge after enable", {31'd0, valid}, 32'd0);
    @(negedge clk);
    check(valid && bin == 5'd0, "R3", "bin 0 at second edge", {26'd0, valid, bin}, {26'd0, 1'b1, 5'd0});
    repeat (n + 2) @(negedge clk);
    check(obs_cnt == n && exp_q.size() == 0, "R6", "bins emitted", 32'(obs_cnt), 32'(n));
    begin
      bit sym_ok = 1;
      for (int k = 0; k < n; k++)
        if (obs[k] + obs[n-1-k] != 2*cm) sym_ok = 0;
      check(sym_ok, "R5", "symmetry about centre", obs[0] + obs[n-1], 2*cm);
      if (n % 2 == 1)
        check(obs[(n-1)/2] == cm, "R5", "middle bin equals centre", obs[(n-1)/2], cm);
    end
    if (prev_n == n) begin
      bit adv_ok = 1;
      for (int k = 0; k < n; k++)
        if (obs[k] - prev[k] != c + 32'(2*k - (n-1)) * s) adv_ok = 0;
      check(adv_ok, "R8", "per-sample advance", obs[0] - prev[0], c - 32'(n-1) * s);
    end
    for (int k = 0; k < n; k++) prev[k] = obs[k];
    prev_n = n;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!valid, "R1", "valid low in reset", {31'd0, valid}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!valid, "R1", "valid low after reset", {31'd0, valid}, 32'd0);

    // R1 R2 R4: 17-bin acquisition comb
    run_sample(32'h0123_4567, 32'h0004_0000, 17);
    check(obs[8] == 32'h0123_4567, "R1", "first centre equals word", obs[8], 32'h0123_4567);
    run_sample(32'h0123_4567, 32'h0004_0000, 17); // R2 R8
    // R8: words change, fine 4-bin comb
    run_sample(32'h0AB0_0000, 32'h0000_9000, 4);
    run_sample(32'h0AB0_0000, 32'h0000_9000, 4);
    run_sample(32'h7000_0001, 32'h0000_9000, 4);
    // R9: single tracking bin
    run_sample(32'h1111_1111, 32'h0100_0000, 1);
    check(obs[0] == cm, "R9", "single bin equals centre", obs[0], cm);
    // R6: zero request gives one bin
    run_sample(32'h0200_0000, 32'h0010_0000, 0);
    check(obs[0] == cm, "R6", "zero count single bin", obs[0], cm);
    // R6: over-range clamps to 32, large words wrap
    run_sample(32'hF000_0000, 32'h0900_0000, 40);
    run_sample(32'hF000_0000, 32'h0900_0000, 32);
    run_sample(32'h3000_0000, 32'h1000_0000, 2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule